// File: doc/BRIEF.md
# External Bus Cycle Sequencer with READY Handshake

This block runs one external read or write bus cycle at a time for a microcontroller-style external bus. The core raises a request with an address, a direction and a per-cycle configuration. The block latches all of these at acceptance. It then drives an optional one-clock address-latch strobe and the active-low read or write strobe. It stretches the command with programmed waitstates, then with READY-controlled waitstates, then adds a trailing recovery gap. When the gap is over, it pulses a one-clock acknowledge back to the core.

READY handling can be switched off, used directly at the sampling edge (synchronous), or taken through a reset-to-not-ready flop chain (asynchronous). The asynchronous path always spends at least one READY waitstate. The trailing gap is one clock for a multiplexed bus plus one clock when the tri-state waitstate is selected.

Top module: `xbus_cycle_ctrl`

## Requirements
- R1: While reset is active and after it is released with no request, ale_o is 0, rd_no and wr_no are 1 and ack_o is 0.
- R2: When mux_mode_i or ale_mode_i is 1 at acceptance, ale_o is high for exactly one clock before the command; otherwise no ale_o pulse occurs. During the command, only wr_no is low when we_i was 1, and only rd_no is low when we_i was 0.
- R3: The command stays active for at least wait_cnt_i + 1 clocks. A low ready_ni before the last of these clocks does not shorten it.
- R4: With rdy_mode_i = 0 (READY off), the command lasts exactly wait_cnt_i + 1 clocks whatever ready_ni does.
- R5: With rdy_mode_i = 1 (synchronous), if ready_ni is low from command clock L onward (clock 0 is the first command clock), the command lasts max(W, L) + 1 clocks, where W is wait_cnt_i.
- R6: With rdy_mode_i = 2 (asynchronous), under the same stimulus the command lasts max(W + 1, L + 2) + 1 clocks, so it is always at least one clock longer than in synchronous mode.
- R7: The number of clocks between the last command clock and the ack_o clock equals mux_mode_i + tri_ws_i (0, 1 or 2).
- R8: ack_o is high for exactly one clock. A request still held during that clock is not accepted at its end. A held request starts its new cycle two clocks after the ack_o clock.
- R9: addr_o carries the address latched at acceptance for the whole command.
- R10: The asynchronous READY chain resets to not-ready. A cycle that starts right after reset with ready_ni low follows the R6 length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Core request, held until ack_o |
| we_i | input | 1 | 1 = write cycle, 0 = read cycle |
| addr_i | input | ADDR_W | Cycle address |
| mux_mode_i | input | 1 | 1 = multiplexed bus |
| ale_mode_i | input | 1 | Force an address phase on a demultiplexed bus |
| wait_cnt_i | input | WAIT_W | Programmed memory-cycle waitstates |
| tri_ws_i | input | 1 | Add a tri-state waitstate after the cycle |
| rdy_mode_i | input | 2 | 0 off, 1 synchronous, 2 asynchronous READY |
| ack_o | output | 1 | One-clock completion pulse |
| addr_o | output | ADDR_W | Latched bus address |
| ale_o | output | 1 | Address latch strobe |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| ready_ni | input | 1 | READY from the external device, active low |

## Verification
On every cycle, the embedded assertions check these local rules: the acknowledge lasts one clock, the address strobe is followed by the command, the command is held while programmed waitstates remain, READY-off and asynchronous modes leave the wait phase as required, the trailing state is entered only when a gap is due, the synchronizer falls only after a low input two clocks earlier, and the address stays stable during the command. The scoreboard alone can show the cycle-exact lengths of the command and the gap as functions of the waitstate count and of the clock at which READY goes low. It also shows the direction of the strobe, the spacing of back-to-back requests, and the behaviour right after reset.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {
    RDY_OFF   = 2'd0,
    RDY_SYNC  = 2'd1,
    RDY_ASYNC = 2'd2
  } rdy_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_CMD   = 3'd2,
    ST_RDYW  = 3'd3,
    ST_TRAIL = 3'd4
  } bus_st_e;
endpackage

// File: rtl/xbus_rdy_sync.sv
module xbus_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rdy_ni,
  output logic rdy_sync_no
);
  logic [STAGES-1:0] chain_q;

  // reset to not-ready (high)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-2:0], rdy_ni};
  end

  assign rdy_sync_no = chain_q[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk2
      // R10
      sync_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(rdy_sync_no) |-> !$past(rdy_ni, 2));
    end
  endgenerate
endmodule

// File: rtl/xbus_down_cnt.sv
module xbus_down_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R3
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i) |-> !zero_o);
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int WAIT_W = 4,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              mux_i,
  input  logic              ale_mode_i,
  input  logic              tri_ws_i,
  input  rdy_mode_e         rdy_mode_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic              rdy_raw_ni,
  input  logic              rdy_sync_ni,
  input  logic              cnt_zero_i,
  output logic              accept_o,
  output logic              cnt_load_o,
  output logic [CNT_W-1:0]  cnt_val_o,
  output logic              cnt_dec_o,
  output logic              ale_o,
  output logic              rd_no,
  output logic              wr_no,
  output logic              ack_o
);
  bus_st_e   st_q, st_d;
  rdy_mode_e rm_q;
  logic      we_q, mux_q, tri_q, ack_q;
  logic      cmd_end, done, rdy_low, cmd_act;
  logic [1:0] gap;

  assign gap     = {1'b0, mux_q} + {1'b0, tri_q};
  assign rdy_low = (rm_q == RDY_SYNC) ? !rdy_raw_ni : !rdy_sync_ni;

  always_comb begin
    st_d       = st_q;
    accept_o   = 1'b0;
    cnt_load_o = 1'b0;
    cnt_val_o  = '0;
    cnt_dec_o  = 1'b0;
    cmd_end    = 1'b0;
    done       = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_i && !ack_q) begin
          accept_o   = 1'b1;
          cnt_load_o = 1'b1;
          cnt_val_o  = CNT_W'(wait_i);
          st_d       = (mux_i || ale_mode_i) ? ST_ADDR : ST_CMD;
        end
      end
      ST_ADDR: st_d = ST_CMD;
      ST_CMD: begin
        if (!cnt_zero_i) cnt_dec_o = 1'b1;
        else begin
          unique case (rm_q)
            RDY_OFF:  cmd_end = 1'b1;
            RDY_SYNC: if (rdy_low) cmd_end = 1'b1; else st_d = ST_RDYW;
            default:  st_d = ST_RDYW; // async: one forced sync waitstate
          endcase
        end
      end
      ST_RDYW: if (rdy_low) cmd_end = 1'b1;
      ST_TRAIL: begin
        if (cnt_zero_i) done = 1'b1;
        else            cnt_dec_o = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
    if (cmd_end) begin
      if (gap == 2'd0) done = 1'b1;
      else begin
        cnt_load_o = 1'b1;
        cnt_val_o  = CNT_W'(gap - 2'd1);
        st_d       = ST_TRAIL;
      end
    end
    if (done) st_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      rm_q  <= RDY_OFF;
      we_q  <= 1'b0;
      mux_q <= 1'b0;
      tri_q <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ack_q <= done;
      if (accept_o) begin
        rm_q  <= rdy_mode_i;
        we_q  <= we_i;
        mux_q <= mux_i;
        tri_q <= tri_ws_i;
      end
    end
  end

  assign cmd_act = (st_q == ST_CMD) || (st_q == ST_RDYW);
  assign ale_o   = (st_q == ST_ADDR);
  assign rd_no   = !(cmd_act && !we_q);
  assign wr_no   = !(cmd_act && we_q);
  assign ack_o   = ack_q;

  // R8
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |=> !ack_q);
  // R8
  no_reaccept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |=> (st_q == ST_IDLE));
  // R2
  ale_then_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> (!rd_no || !wr_no));
  // R3
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CMD && !cnt_zero_i) |=> (st_q == ST_CMD));
  // R4
  rdy_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CMD && cnt_zero_i && rm_q == RDY_OFF) |=> (rd_no && wr_no));
  // R6
  async_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CMD && cnt_zero_i && rm_q == RDY_ASYNC) |=> (st_q == ST_RDYW));
  // R7
  gap_due_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TRAIL) |-> (mux_q || tri_q));
endmodule

// File: rtl/xbus_cycle_ctrl.sv
module xbus_cycle_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int WAIT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mux_mode_i,
  input  logic              ale_mode_i,
  input  logic [WAIT_W-1:0] wait_cnt_i,
  input  logic              tri_ws_i,
  input  logic [1:0]        rdy_mode_i,
  output logic              ack_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ale_o,
  output logic              rd_no,
  output logic              wr_no,
  input  logic              ready_ni
);
  localparam int CNT_W = (WAIT_W < 2) ? 2 : WAIT_W;

  logic              rdy_sync_n, cnt_zero, cnt_load, cnt_dec, accept;
  logic [CNT_W-1:0]  cnt_val;
  logic [ADDR_W-1:0] addr_q;

  xbus_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rdy_ni      (ready_ni),
    .rdy_sync_no (rdy_sync_n)
  );

  xbus_down_cnt #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cnt_load),
    .val_i  (cnt_val),
    .dec_i  (cnt_dec),
    .zero_o (cnt_zero)
  );

  xbus_seq #(.WAIT_W(WAIT_W), .CNT_W(CNT_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .we_i        (we_i),
    .mux_i       (mux_mode_i),
    .ale_mode_i  (ale_mode_i),
    .tri_ws_i    (tri_ws_i),
    .rdy_mode_i  (rdy_mode_e'(rdy_mode_i)),
    .wait_i      (wait_cnt_i),
    .rdy_raw_ni  (ready_ni),
    .rdy_sync_ni (rdy_sync_n),
    .cnt_zero_i  (cnt_zero),
    .accept_o    (accept),
    .cnt_load_o  (cnt_load),
    .cnt_val_o   (cnt_val),
    .cnt_dec_o   (cnt_dec),
    .ale_o       (ale_o),
    .rd_no       (rd_no),
    .wr_no       (wr_no),
    .ack_o       (ack_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (accept) addr_q <= addr_i;
  end

  assign addr_o = addr_q;

  // R9
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!rd_no || !wr_no) && !$past(rd_no && wr_no)) |-> $stable(addr_o));
endmodule

// File: tb/sim_xbus_cycle_ctrl.sv
module sim_xbus_cycle_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, mux = 1'b0, alem = 1'b0, triw = 1'b0;
  logic [15:0] addr = '0;
  logic [3:0]  wcnt = '0;
  logic [1:0]  rmode = '0;
  logic        ready_n = 1'b1;
  logic        ack, ale, rd_n, wr_n;
  logic [15:0] addr_out;

  int checks = 0, fails = 0, cyc = 0;

  typedef struct {
    logic [15:0] addr;
    logic we, mux, alem, triw;
    int   w;
    int   rm;
    int   l;
    bit   b2b;
    string tag;
  } item_t;
  item_t q[$];

  xbus_cycle_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .mux_mode_i(mux), .ale_mode_i(alem), .wait_cnt_i(wcnt), .tri_ws_i(triw),
    .rdy_mode_i(rmode), .ack_o(ack), .addr_o(addr_out), .ale_o(ale),
    .rd_no(rd_n), .wr_no(wr_n), .ready_ni(ready_n)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int exp_len(input item_t e);
    if (e.rm == 0) return e.w + 1;
    if (e.rm == 1) return max2(e.w, e.l) + 1;
    return max2(e.w + 1, e.l + 2) + 1;
  endfunction

  // driver
  task automatic txn(input logic [15:0] a, input logic w_e, input logic m,
                     input logic am, input logic t, input int w, input int rm,
                     input int l, input bit hold, input bit b2b, input string tag);
    item_t it;
    it.addr = a; it.we = w_e; it.mux = m; it.alem = am; it.triw = t;
    it.w = w; it.rm = rm; it.l = l; it.b2b = b2b; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    req = 1'b1; addr = a; we = w_e; mux = m; alem = am; triw = t;
    wcnt = 4'(w); rmode = 2'(rm);
    do @(negedge clk); while (!ack);
    if (!hold) begin
      req = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  // monitor
  initial begin
    int last_ack = -100;
    forever begin
      @(negedge clk);
      if (rst_n && (ale || !rd_n || !wr_n)) begin
        item_t e;
        int na, nc, ng;
        bit bad_dir, bad_addr, bad_ale;
        na = 0; nc = 0; ng = 0; bad_dir = 0; bad_addr = 0; bad_ale = 0;
        if (q.size() == 0) begin
          chk("R2 unexpected cycle", 1, 0);
        end else begin
          e = q.pop_front();
          if (e.b2b) chk("R8 back-to-back start", cyc - last_ack, 2);
          while (ale && rd_n && wr_n && na < 10) begin
            na++;
            @(negedge clk);
          end
          chk("R2 ale clocks", na, (e.mux || e.alem) ? 1 : 0);
          while ((!rd_n || !wr_n) && nc < 100) begin
            if (nc >= e.l) ready_n = 1'b0;
            if (e.we ? !(!wr_n && rd_n) : !(!rd_n && wr_n)) bad_dir = 1;
            if (addr_out != e.addr) bad_addr = 1;
            if (ale) bad_ale = 1;
            nc++;
            @(negedge clk);
          end
          ready_n = 1'b1;
          chk("R2 strobe direction", bad_dir, 0);
          chk("R2 no ale in command", bad_ale, 0);
          chk("R9 address held", bad_addr, 0);
          chk("R3 minimum length", (nc >= e.w + 1) ? 1 : 0, 1);
          chk(e.tag, nc, exp_len(e));
          while (!ack && ng < 10) begin
            ng++;
            @(negedge clk);
          end
          chk("R7 trailing gap", ng, int'(e.mux) + int'(e.triw));
          last_ack = cyc;
          @(negedge clk);
          chk("R8 ack one clock", ack, 0);
          chk("R8 no restart in ack clock", (ale || !rd_n || !wr_n) ? 1 : 0, 0);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 during reset
    chk("R1 ale in reset", ale, 0);
    chk("R1 strobes in reset", {rd_n, wr_n}, 3);
    chk("R1 ack in reset", ack, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle strobes", {ale, rd_n, wr_n, ack}, 6);

    //   addr      we  mux alem tri w  rm l   hold b2b tag
    txn(16'h1234, 0, 0, 0, 0, 0, 2, 0, 0, 0, "R10 async after reset");
    txn(16'h0001, 0, 0, 0, 0, 0, 0, 99, 0, 0, "R4 off w0");
    txn(16'h00f0, 1, 0, 0, 0, 3, 0, 0, 0, 0, "R4 off ready ignored");
    txn(16'h0a0a, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R5 sync w0");
    txn(16'h5555, 1, 0, 0, 0, 2, 1, 5, 0, 0, "R5 sync late ready");
    txn(16'hbeef, 0, 0, 0, 0, 3, 1, 0, 0, 0, "R3 early ready ignored");
    txn(16'hcafe, 1, 0, 0, 0, 2, 2, 0, 0, 0, "R6 async waits dominate");
    txn(16'h7777, 0, 0, 0, 0, 0, 2, 4, 0, 0, "R6 async late ready");
    txn(16'h1111, 0, 1, 0, 1, 1, 1, 0, 0, 0, "R7 mux tri");
    txn(16'h2222, 1, 1, 0, 0, 2, 0, 0, 0, 0, "R7 mux only");
    txn(16'h3333, 0, 0, 1, 1, 1, 2, 1, 1, 0, "R2 ale mode demux");
    txn(16'h4444, 1, 0, 0, 0, 0, 1, 0, 0, 1, "R8 held request");
    txn(16'hffff, 0, 0, 0, 0, 15, 0, 0, 0, 0, "R3 max waits");

    repeat (10) @(negedge clk);
    chk("R8 all cycles completed", q.size(), 0);
    summary();
    $finish;
  end
endmodule